// File: doc/BRIEF.md
# Output-Compare Pin Waveform Channel

This block is a single compare channel that watches a shared 16-bit prescaled time-base counter, which is built elsewhere. Software loads a compare value, picks what the attached output pin should do on a hit, and sets a mode bit that hands the channel to compare duty. Each time the counter steps onto the compare value, the channel raises a hit flag and updates the pin in hardware. The pin can be set high, set low, flipped, or left alone.

The flag can drive an interrupt line through a per-channel enable. The usual way to make a duty-cycled waveform is to select the flip action and, in the interrupt handler, add the next high or low interval to the compare value. With the quick-acknowledge option on, writing the compare register also clears the flag, so each edge costs only one register write. Compare values wrap modulo 2^16, so a hit that lands after the counter rolls over behaves the same as any other hit.

Register map (word addresses on `wr_addr`/`rd_addr`): 0 = compare value, 1 = control, 2 = hit flag.

Top module: `ocpin_channel`

## Requirements
- R1: After reset the pin, the hit flag and the interrupt are 0, and the control register (address 1) reads back 0.
- R2: With control bit 0 (compare mode) at 0, a counter hit neither sets the flag nor changes the pin.
- R3: Control bits [2:1] select the action on a hit: 2'b11 sets the pin to 1, 2'b10 clears it to 0, and 2'b01 inverts it.
- R4: A hit occurs when `cnt_tick` is 1 and `cnt_value` equals the compare register (address 0). The flag and the pin change at the clock edge that ends that cycle.
- R5: A hit is taken only in a cycle with `cnt_tick` at 1. While the counter holds the matching value with `cnt_tick` at 0, nothing changes, and a flag cleared in that time stays 0.
- R6: Hits work across the counter wrap: a compare value of 16'hFFFF is hit, and a compare value of 2 is hit after the counter steps through 0 and 1.
- R7: Action 2'b00 leaves the pin at its last value on a hit, but the flag is still set.
- R8: `irq` is 1 exactly when the flag is 1 and control bit 3 (interrupt enable) is 1.
- R9: Writing a word with bit 0 set to address 2 clears the flag. Writing a word with bit 0 at 0 has no effect on the flag.
- R10: With control bit 4 (quick acknowledge) at 1, a write to the compare register clears the flag. With that bit at 0, a compare write leaves the flag set.
- R11: A hit in the same cycle as a flag-clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | One-cycle strobe marking that the shared counter took a new value |
| cnt_value | input | 16 | Current value of the shared counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pin_out | output | 1 | Output pin driven by the hit action |
| flag_out | output | 1 | Hit flag |
| irq | output | 1 | Interrupt request |

## Verification
The compare path is driven with ticks that carry non-matching values, with a matching value held while no tick arrives, and with matching ticks. These separate a correct tick-qualified hit from a level-sensitive or an untimed compare. Each of the four action codes is tried against a known prior pin state, so that swapped decodes show up. Compare values at 16'hFFFF and just past the rollover confirm that no wrap logic is needed. Flag clearing is tried through a zero write, a one write, compare writes with and without quick acknowledge, and a clear that coincides with a hit, which pins down the priority.

// File: rtl/ocg_pkg.sv
// Shared types and register addresses for the output-compare channel.
// Assumes a 2-bit word address space on the register bus.
package ocg_pkg;
    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

    localparam logic [1:0] REG_CMP  = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_FLAG = 2'd2;

    localparam int CTRL_W    = 5;
    localparam int BIT_MODE  = 0;
    localparam int BIT_IE    = 3;
    localparam int BIT_QACK  = 4;
endpackage

// File: rtl/ocg_match.sv
// Hit detector: flags the cycle in which the counter strobes onto the
// compare value. Assumes cnt_value is stable with the strobe.
module ocg_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic [W-1:0] cnt_value,
    input  logic [W-1:0] cmp_val,
    input  logic         cmp_mode,
    output logic         hit
);
    // Purpose: qualify equality with the counter strobe and compare mode.
    always_comb begin
        hit = cnt_tick && cmp_mode && (cnt_value == cmp_val);
    end

    // R2: no hit while the channel is not in compare mode
    a_r2_no_hit_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_mode |-> !hit);
    // R5: a hit needs the counter strobe
    a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |-> !hit);
endmodule

// File: rtl/ocg_pin.sv
// Pin driver: applies the selected action on each hit and holds the pin
// otherwise. Assumes hit is a single-cycle pulse.
module ocg_pin
    import ocg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  pin_act_e act,
    output logic     pin
);
    // Purpose: update the pin register from the action on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (hit) begin
            case (act)
                ACT_HIGH:   pin <= 1'b1;
                ACT_LOW:    pin <= 1'b0;
                ACT_TOGGLE: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end

    // R3: high action
    a_r3_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_HIGH) |=> pin);
    // R3: low action
    a_r3_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_LOW) |=> !pin);
    // R3: invert action
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOGGLE) |=> pin != $past(pin));
    // R7: off action and idle cycles keep the pin
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || act == ACT_OFF) |=> $stable(pin));
endmodule

// File: rtl/ocg_regs.sv
// Register file: compare value, control bits and the hit flag, plus the
// read mux. Assumes the hit pulse comes from ocg_match in the same cycle.
module ocg_regs
    import ocg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    input  logic         hit,
    output logic [W-1:0] cmp_val,
    output logic         cmp_mode,
    output pin_act_e     act,
    output logic         flag,
    output logic         irq,
    output logic [W-1:0] rd_data
);
    logic [CTRL_W-1:0] ctrl;
    logic              wr_cmp;
    logic              wr_flag1;
    logic              ie;
    logic              qack;

    assign wr_cmp   = wr_en && (wr_addr == REG_CMP);
    assign wr_flag1 = wr_en && (wr_addr == REG_FLAG) && wr_data[0];
    assign ie       = ctrl[BIT_IE];
    assign qack     = ctrl[BIT_QACK];
    assign cmp_mode = ctrl[BIT_MODE];
    assign act      = pin_act_e'(ctrl[2:1]);
    assign irq      = flag && ie;

    // Purpose: hold the compare value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (wr_cmp) cmp_val <= wr_data;
    end

    // Purpose: hold the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl <= '0;
        else if (wr_en && wr_addr == REG_CTRL)    ctrl <= wr_data[CTRL_W-1:0];
    end

    // Purpose: set the flag on a hit, clear it by write-one or quick acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (hit)                        flag <= 1'b1;
        else if (wr_flag1 || (wr_cmp && qack)) flag <= 1'b0;
    end

    // Purpose: select the register shown on the read port.
    always_comb begin
        case (rd_addr)
            REG_CMP:  rd_data = cmp_val;
            REG_CTRL: rd_data = {{(W-CTRL_W){1'b0}}, ctrl};
            REG_FLAG: rd_data = {{(W-1){1'b0}}, flag};
            default:  rd_data = '0;
        endcase
    end

    // R4, R11: a hit always leaves the flag set
    a_r11_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R10: quick acknowledge clears on compare write
    a_r10_qack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && qack && !hit) |=> !flag);
    // R9, R10: without a clearing write the flag stays set
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_flag1 && !(wr_cmp && qack)) |=> flag);
    // R8: no interrupt while disabled
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);
endmodule

// File: rtl/ocpin_channel.sv
// Top of one output-compare channel: register file, hit detector and pin
// driver. Assumes the shared counter and its prescaler live outside.
module ocpin_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pin_out,
    output logic             flag_out,
    output logic             irq
);
    import ocg_pkg::*;

    logic [CNT_W-1:0] cmp_val;
    logic             cmp_mode;
    pin_act_e         act;
    logic             hit;

    ocg_regs #(.W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .hit(hit), .cmp_val(cmp_val),
        .cmp_mode(cmp_mode), .act(act), .flag(flag_out), .irq(irq),
        .rd_data(rd_data)
    );

    ocg_match #(.W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_value(cnt_value),
        .cmp_val(cmp_val), .cmp_mode(cmp_mode), .hit(hit)
    );

    ocg_pin u_pin (
        .clk(clk), .rst_n(rst_n), .hit(hit), .act(act), .pin(pin_out)
    );

    // R1: everything quiet in the cycle after reset
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (!pin_out && !flag_out && !irq));
    // R4: flag rises only after a hit
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out) |-> $past(hit));
endmodule

// File: tb/sim_ocpin_channel.sv
`timescale 1ns/1ps
module sim_ocpin_channel;
    typedef struct {
        logic  pin;
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [15:0] cnt_value = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd1;
    logic [15:0] rd_data;
    logic        pin_out, flag_out, irq;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ocpin_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_value(cnt_value),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_out(pin_out), .flag_out(flag_out), .irq(irq)
    );

    // Driver: one cycle of stimulus, then queue what must be seen after the edge.
    task automatic cyc(input logic t, input logic [15:0] c, input logic we,
                       input logic [1:0] a, input logic [15:0] d,
                       input logic ep, input logic ef, input logic ei,
                       input string tag);
        exp_t e;
        @(negedge clk);
        cnt_tick = t; cnt_value = c; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        cnt_tick = 1'b0; wr_en = 1'b0;
        e.pin = ep; e.flag = ef; e.irq = ei; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare queued expectations away from the clock edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if ({pin_out, flag_out, irq} !== {e.pin, e.flag, e.irq}) begin
                n_bad++;
                $display("FAIL %s: pin/flag/irq got %b%b%b expected %b%b%b",
                         e.tag, pin_out, flag_out, irq, e.pin, e.flag, e.irq);
            end
        end
    end

    task automatic chk_rd(input logic [15:0] exp, input string tag);
        @(negedge clk);
        #0.5;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data got %h expected %h", tag, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_rd(16'h0000, "R1 ctrl after reset");
        cyc(0, 0, 1, 2'd0, 16'd5, 0, 0, 0, "R1 quiet after reset");
        // compare mode off, action high
        cyc(0, 0, 1, 2'd1, 16'h0006, 0, 0, 0, "R2 setup");
        cyc(1, 5, 0, 2'd0, 0, 0, 0, 0, "R2 capture mode ignores hit");
        // compare mode on, action high
        cyc(0, 5, 1, 2'd1, 16'h0007, 0, 0, 0, "R3 setup high");
        cyc(1, 4, 0, 2'd0, 0, 0, 0, 0, "R4 tick with other value");
        cyc(0, 5, 0, 2'd0, 0, 0, 0, 0, "R5 match without tick");
        cyc(1, 5, 0, 2'd0, 0, 1, 1, 0, "R4 R3 hit drives high");
        cyc(0, 5, 0, 2'd0, 0, 1, 1, 0, "R5 held value no retrigger");
        cyc(0, 5, 1, 2'd2, 16'h0000, 1, 1, 0, "R9 zero write keeps flag");
        cyc(0, 5, 1, 2'd2, 16'h0001, 1, 0, 0, "R9 write one clears");
        cyc(0, 5, 0, 2'd0, 0, 1, 0, 0, "R5 no reset of flag");
        cyc(0, 5, 0, 2'd0, 0, 1, 0, 0, "R5 no reset of flag 2");
        // action low
        cyc(0, 5, 1, 2'd1, 16'h0005, 1, 0, 0, "R3 setup low");
        cyc(0, 5, 1, 2'd0, 16'd7, 1, 0, 0, "R3 load 7");
        cyc(1, 7, 0, 2'd0, 0, 0, 1, 0, "R3 hit drives low");
        cyc(0, 7, 1, 2'd2, 16'h0001, 0, 0, 0, "R9 clear");
        // action invert across the wrap
        cyc(0, 7, 1, 2'd1, 16'h0003, 0, 0, 0, "R3 setup toggle");
        cyc(0, 7, 1, 2'd0, 16'hFFFF, 0, 0, 0, "R6 load FFFF");
        cyc(1, 16'hFFFF, 0, 2'd0, 0, 1, 1, 0, "R6 hit at FFFF toggles");
        cyc(0, 16'hFFFF, 1, 2'd2, 16'h0001, 1, 0, 0, "R9 clear");
        cyc(0, 16'hFFFF, 1, 2'd0, 16'd2, 1, 0, 0, "R6 load 2");
        cyc(1, 0, 0, 2'd0, 0, 1, 0, 0, "R6 wrap to 0");
        cyc(1, 1, 0, 2'd0, 0, 1, 0, 0, "R6 step 1");
        cyc(1, 2, 0, 2'd0, 0, 0, 1, 0, "R6 hit after wrap toggles");
        // interrupt gating
        cyc(0, 2, 1, 2'd1, 16'h000B, 0, 1, 1, "R8 enable raises irq");
        cyc(0, 2, 1, 2'd1, 16'h0003, 0, 1, 0, "R8 disable drops irq");
        cyc(0, 2, 1, 2'd1, 16'h000B, 0, 1, 1, "R8 re-enable");
        cyc(0, 2, 1, 2'd2, 16'h0001, 0, 0, 0, "R8 clear flag drops irq");
        // action off
        cyc(0, 2, 1, 2'd1, 16'h0009, 0, 0, 0, "R7 setup off");
        cyc(0, 2, 1, 2'd0, 16'd9, 0, 0, 0, "R7 load 9");
        cyc(1, 9, 0, 2'd0, 0, 0, 1, 1, "R7 off keeps pin, sets flag");
        // quick acknowledge
        cyc(0, 9, 1, 2'd0, 16'd20, 0, 1, 1, "R10 compare write keeps flag");
        cyc(0, 9, 1, 2'd1, 16'h0019, 0, 1, 1, "R10 enable quick ack");
        chk_rd(16'h0019, "R10 ctrl readback");
        cyc(0, 9, 1, 2'd0, 16'd30, 0, 0, 0, "R10 compare write clears");
        // hit versus simultaneous clear
        cyc(1, 30, 1, 2'd2, 16'h0001, 0, 1, 1, "R11 hit beats clear");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule